// File: doc/BRIEF.md
# Edge-Triggered Time-Counter Capture Unit

This block timestamps activity on eight asynchronous event inputs against a free-running time counter that arrives as a seconds bus and a 30-bit nanoseconds bus. Each channel has two independent capture paths, one for rising and one for falling transitions. Each path has its own capture enable and its own lock. When an enabled transition is seen, the counter value is stored and a per-channel, per-edge status bit is raised. Software reads the stored values through a small word-addressed register port. A channel-select field steers a four-register readout window onto one channel at a time.

Status bits are cleared by writing ones. Interrupt enables sit at the same bit positions as the status bits and are changed through separate set and clear addresses, so no read-modify-write is needed. A single interrupt line is asserted while any enabled status bit is pending. The inputs go through a synchroniser and an edge detector before they are used. The lock option keeps the first timestamp of a burst until software has acknowledged it.

Top module: `evt_stamp_unit`

## Requirements
- R1: After reset, the configuration, interrupt enables, status bits, channel select and every stored timestamp read as zero, and `irq` is low.
- R2: When configuration bit ch (address 0) is set, a rising transition on `ev_in[ch]` stores the `time_sec`/`time_ns` values present at the third rising clock edge after the input changes. It also sets status bit 16+ch (address 1) on that same edge.
- R3: When configuration bit 8+ch is set, a falling transition on `ev_in[ch]` stores the counter in the same way and sets status bit 24+ch.
- R4: A transition whose edge type is not enabled for its channel leaves both the stored timestamp and the status bit unchanged.
- R5: While lock bit 16+ch (rising) or 24+ch (falling) is set in the configuration and the matching status bit is pending, further transitions of that type do not overwrite the stored timestamp. Without the lock, every enabled transition overwrites it.
- R6: Writing address 1 clears each status bit written as 1. Bits written as 0 are unchanged.
- R7: Writing address 2 sets, and writing address 3 clears, each interrupt enable written as 1, using the status bit positions. Reading either address returns the enables.
- R8: `irq` is high exactly when some status bit is set and its enable is set. It follows state changes on the same clock edge.
- R9: When a capture and a write-one-to-clear hit the same status bit on the same edge, the bit stays set.
- R10: Bits 10:8 of address 4 select a channel. Addresses 5, 6, 7 and 8 return that channel's rising seconds, rising nanoseconds, falling seconds and falling nanoseconds, each zero-extended to 32 bits.
- R11: `rd_data` is loaded on the clock edge that samples `rd_en` high, and it holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_in | input | N_CH | Asynchronous event inputs |
| time_sec | input | SEC_W | Time counter, seconds |
| time_ns | input | NS_W | Time counter, nanoseconds |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, enabled pending status |

## Verification
A change on an event input is captured on the third rising clock edge after it: two synchroniser flops, then the edge-detect register. Status and `irq` change on that same edge. A register write acts on the edge that samples it, and read data appears one edge after the read strobe. The bench changes the time counter to a new value on every falling clock edge and expects the value driven two falling edges after the input change. A capture that lands one edge early or late therefore produces a mismatched timestamp. All outputs are sampled on falling edges, once the edge that updates them has passed.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
   localparam int unsigned REG_AW = 4;
   localparam int unsigned REG_DW = 32;
   localparam int unsigned MAX_CH = 8;

   // configuration field positions
   localparam int unsigned CFG_REN_LSB = 0;
   localparam int unsigned CFG_FEN_LSB = 8;
   localparam int unsigned CFG_RLK_LSB = 16;
   localparam int unsigned CFG_FLK_LSB = 24;

   // status / interrupt enable positions
   localparam int unsigned ST_RISE_LSB = 16;
   localparam int unsigned ST_FALL_LSB = 24;

   // channel select field
   localparam int unsigned SEL_LSB = 8;
   localparam int unsigned SEL_W   = 3;

   localparam logic [REG_AW-1:0] ADR_CFG      = 4'd0;
   localparam logic [REG_AW-1:0] ADR_STAT     = 4'd1;
   localparam logic [REG_AW-1:0] ADR_IEN_SET  = 4'd2;
   localparam logic [REG_AW-1:0] ADR_IEN_CLR  = 4'd3;
   localparam logic [REG_AW-1:0] ADR_SEL      = 4'd4;
   localparam logic [REG_AW-1:0] ADR_RISE_SEC = 4'd5;
   localparam logic [REG_AW-1:0] ADR_RISE_NS  = 4'd6;
   localparam logic [REG_AW-1:0] ADR_FALL_SEC = 4'd7;
   localparam logic [REG_AW-1:0] ADR_FALL_NS  = 4'd8;
endpackage

// File: rtl/evt_stamp_sync.sv
module evt_stamp_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [STAGES-1:0][W-1:0] sh;
   logic [W-1:0]             prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         prev <= '0;
      end else begin
         sh   <= {sh[STAGES-2:0], din};
         prev <= sh[STAGES-1];
      end
   end

   assign rise = sh[STAGES-1] & ~prev;
   assign fall = ~sh[STAGES-1] & prev;
endmodule

// File: rtl/evt_stamp_slot.sv
module evt_stamp_slot #(
   parameter int unsigned SEC_W = 32,
   parameter int unsigned NS_W  = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             hold,
   input  logic [SEC_W-1:0] t_sec,
   input  logic [NS_W-1:0]  t_ns,
   output logic [SEC_W-1:0] q_sec,
   output logic [NS_W-1:0]  q_ns
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_sec <= '0;
         q_ns  <= '0;
      end else if (fire && !hold) begin
         q_sec <= t_sec;
         q_ns  <= t_ns;
      end
   end
endmodule

// File: rtl/evt_stamp_regs.sv
module evt_stamp_regs
   import evt_stamp_pkg::*;
#(
   parameter int unsigned N_CH  = 8,
   parameter int unsigned SEC_W = 32,
   parameter int unsigned NS_W  = 30
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [REG_AW-1:0]          wr_addr,
   input  logic [REG_DW-1:0]          wr_data,
   input  logic                       rd_en,
   input  logic [REG_AW-1:0]          rd_addr,
   output logic [REG_DW-1:0]          rd_data,
   input  logic [N_CH-1:0]            rise_fire,
   input  logic [N_CH-1:0]            fall_fire,
   input  logic [N_CH-1:0][SEC_W-1:0] rise_sec_q,
   input  logic [N_CH-1:0][SEC_W-1:0] fall_sec_q,
   input  logic [N_CH-1:0][NS_W-1:0]  rise_ns_q,
   input  logic [N_CH-1:0][NS_W-1:0]  fall_ns_q,
   output logic [N_CH-1:0]            rise_en,
   output logic [N_CH-1:0]            fall_en,
   output logic [N_CH-1:0]            rise_lock,
   output logic [N_CH-1:0]            fall_lock,
   output logic [N_CH-1:0]            rise_pend,
   output logic [N_CH-1:0]            fall_pend,
   output logic [N_CH-1:0]            rise_ien,
   output logic [N_CH-1:0]            fall_ien,
   output logic                       irq
);
   logic              wr_cfg, wr_st, wr_set, wr_clr, wr_sel;
   logic [N_CH-1:0]   clr_rise, clr_fall;
   logic [SEL_W-1:0]  sel_q;
   logic              sel_ok;
   logic [REG_DW-1:0] rd_next;

   assign wr_cfg = wr_en && (wr_addr == ADR_CFG);
   assign wr_st  = wr_en && (wr_addr == ADR_STAT);
   assign wr_set = wr_en && (wr_addr == ADR_IEN_SET);
   assign wr_clr = wr_en && (wr_addr == ADR_IEN_CLR);
   assign wr_sel = wr_en && (wr_addr == ADR_SEL);

   assign clr_rise = wr_st ? wr_data[ST_RISE_LSB +: N_CH] : '0;
   assign clr_fall = wr_st ? wr_data[ST_FALL_LSB +: N_CH] : '0;

   // configuration
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_en   <= '0;
         fall_en   <= '0;
         rise_lock <= '0;
         fall_lock <= '0;
      end else if (wr_cfg) begin
         rise_en   <= wr_data[CFG_REN_LSB +: N_CH];
         fall_en   <= wr_data[CFG_FEN_LSB +: N_CH];
         rise_lock <= wr_data[CFG_RLK_LSB +: N_CH];
         fall_lock <= wr_data[CFG_FLK_LSB +: N_CH];
      end
   end

   // status: a capture outranks a same-edge clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_pend <= '0;
         fall_pend <= '0;
      end else begin
         rise_pend <= (rise_pend & ~clr_rise) | rise_fire;
         fall_pend <= (fall_pend & ~clr_fall) | fall_fire;
      end
   end

   // interrupt enables through set / clear addresses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_ien <= '0;
         fall_ien <= '0;
      end else if (wr_set) begin
         rise_ien <= rise_ien | wr_data[ST_RISE_LSB +: N_CH];
         fall_ien <= fall_ien | wr_data[ST_FALL_LSB +: N_CH];
      end else if (wr_clr) begin
         rise_ien <= rise_ien & ~wr_data[ST_RISE_LSB +: N_CH];
         fall_ien <= fall_ien & ~wr_data[ST_FALL_LSB +: N_CH];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (wr_sel) sel_q <= wr_data[SEL_LSB +: SEL_W];
   end

   assign sel_ok = (32'(sel_q) < N_CH);

   always_comb begin
      rd_next = '0;
      case (rd_addr)
         ADR_CFG: begin
            rd_next[CFG_REN_LSB +: N_CH] = rise_en;
            rd_next[CFG_FEN_LSB +: N_CH] = fall_en;
            rd_next[CFG_RLK_LSB +: N_CH] = rise_lock;
            rd_next[CFG_FLK_LSB +: N_CH] = fall_lock;
         end
         ADR_STAT: begin
            rd_next[ST_RISE_LSB +: N_CH] = rise_pend;
            rd_next[ST_FALL_LSB +: N_CH] = fall_pend;
         end
         ADR_IEN_SET, ADR_IEN_CLR: begin
            rd_next[ST_RISE_LSB +: N_CH] = rise_ien;
            rd_next[ST_FALL_LSB +: N_CH] = fall_ien;
         end
         ADR_SEL:      rd_next[SEL_LSB +: SEL_W] = sel_q;
         ADR_RISE_SEC: if (sel_ok) rd_next[SEC_W-1:0] = rise_sec_q[sel_q];
         ADR_RISE_NS:  if (sel_ok) rd_next[NS_W-1:0]  = rise_ns_q[sel_q];
         ADR_FALL_SEC: if (sel_ok) rd_next[SEC_W-1:0] = fall_sec_q[sel_q];
         ADR_FALL_NS:  if (sel_ok) rd_next[NS_W-1:0]  = fall_ns_q[sel_q];
         default:      rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_next;
   end

   assign irq = |({fall_pend, rise_pend} & {fall_ien, rise_ien});
endmodule

// File: rtl/evt_stamp_unit.sv
module evt_stamp_unit
   import evt_stamp_pkg::*;
#(
   parameter int unsigned N_CH        = 8,
   parameter int unsigned SEC_W       = 32,
   parameter int unsigned NS_W        = 30,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CH-1:0]   ev_in,
   input  logic [SEC_W-1:0]  time_sec,
   input  logic [NS_W-1:0]   time_ns,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [REG_DW-1:0] wr_data,
   input  logic              rd_en,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [REG_DW-1:0] rd_data,
   output logic              irq
);
   // elaboration-time parameter checks
   if (N_CH < 1 || N_CH > MAX_CH) begin : g_bad_ch
      $error("evt_stamp_unit: N_CH must lie in 1..8");
   end
   if (SEC_W < 1 || SEC_W > REG_DW) begin : g_bad_sec
      $error("evt_stamp_unit: SEC_W must fit a register word");
   end
   if (NS_W < 1 || NS_W > REG_DW) begin : g_bad_ns
      $error("evt_stamp_unit: NS_W must fit a register word");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("evt_stamp_unit: SYNC_STAGES must be at least 2");
   end

   logic [N_CH-1:0] rise_edge, fall_edge, rise_fire, fall_fire;
   logic [N_CH-1:0] rise_en, fall_en, rise_lock, fall_lock;
   logic [N_CH-1:0] rise_pend, fall_pend, rise_ien, fall_ien;
   logic [N_CH-1:0][SEC_W-1:0] rise_sec_q, fall_sec_q;
   logic [N_CH-1:0][NS_W-1:0]  rise_ns_q, fall_ns_q;

   evt_stamp_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ev_in),
      .rise (rise_edge),
      .fall (fall_edge)
   );

   assign rise_fire = rise_edge & rise_en;
   assign fall_fire = fall_edge & fall_en;

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      evt_stamp_slot #(.SEC_W(SEC_W), .NS_W(NS_W)) u_rise (
         .clk  (clk),
         .rst_n(rst_n),
         .fire (rise_fire[ch]),
         .hold (rise_lock[ch] & rise_pend[ch]),
         .t_sec(time_sec),
         .t_ns (time_ns),
         .q_sec(rise_sec_q[ch]),
         .q_ns (rise_ns_q[ch])
      );
      evt_stamp_slot #(.SEC_W(SEC_W), .NS_W(NS_W)) u_fall (
         .clk  (clk),
         .rst_n(rst_n),
         .fire (fall_fire[ch]),
         .hold (fall_lock[ch] & fall_pend[ch]),
         .t_sec(time_sec),
         .t_ns (time_ns),
         .q_sec(fall_sec_q[ch]),
         .q_ns (fall_ns_q[ch])
      );
   end

   evt_stamp_regs #(.N_CH(N_CH), .SEC_W(SEC_W), .NS_W(NS_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .rise_fire (rise_fire),
      .fall_fire (fall_fire),
      .rise_sec_q(rise_sec_q),
      .fall_sec_q(fall_sec_q),
      .rise_ns_q (rise_ns_q),
      .fall_ns_q (fall_ns_q),
      .rise_en   (rise_en),
      .fall_en   (fall_en),
      .rise_lock (rise_lock),
      .fall_lock (fall_lock),
      .rise_pend (rise_pend),
      .fall_pend (fall_pend),
      .rise_ien  (rise_ien),
      .fall_ien  (fall_ien),
      .irq       (irq)
   );
endmodule

// File: rtl/evt_stamp_chk.sv
module evt_stamp_chk
   import evt_stamp_pkg::*;
#(
   parameter int unsigned N_CH  = 8,
   parameter int unsigned SEC_W = 32,
   parameter int unsigned NS_W  = 30
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [REG_AW-1:0]          wr_addr,
   input logic [REG_DW-1:0]          wr_data,
   input logic                       irq,
   input logic [N_CH-1:0]            rise_fire,
   input logic [N_CH-1:0]            rise_en,
   input logic [N_CH-1:0]            fall_en,
   input logic [N_CH-1:0]            rise_lock,
   input logic [N_CH-1:0]            fall_lock,
   input logic [N_CH-1:0]            rise_pend,
   input logic [N_CH-1:0]            fall_pend,
   input logic [N_CH-1:0]            rise_ien,
   input logic [N_CH-1:0]            fall_ien,
   input logic [N_CH-1:0][SEC_W-1:0] rise_sec_q,
   input logic [N_CH-1:0][SEC_W-1:0] fall_sec_q,
   input logic [N_CH-1:0][NS_W-1:0]  rise_ns_q,
   input logic [N_CH-1:0][NS_W-1:0]  fall_ns_q
);
   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rise_pend == '0 && fall_pend == '0 && !irq &&
                        rise_sec_q == '0 && fall_ns_q == '0));

   assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((rise_pend | fall_pend) != '0));

   assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((rise_ien | fall_ien) == '0) |-> !irq);

   assert_capture_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_fire != '0) |=> ((rise_pend & $past(rise_fire)) == $past(rise_fire)));

   assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADR_STAT &&
       ((wr_data[ST_RISE_LSB +: N_CH] & ~rise_fire) != '0))
      |=> ((rise_pend & $past(wr_data[ST_RISE_LSB +: N_CH] & ~rise_fire)) == '0));

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_chk
      assert_no_rise_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!rise_en[ch] && !rise_pend[ch]) |=> !rise_pend[ch]);
      assert_no_fall_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!fall_en[ch] && !fall_pend[ch]) |=> !fall_pend[ch]);
      assert_rise_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (rise_lock[ch] && rise_pend[ch]) |=>
            ($stable(rise_sec_q[ch]) && $stable(rise_ns_q[ch])));
      assert_fall_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (fall_lock[ch] && fall_pend[ch]) |=>
            ($stable(fall_sec_q[ch]) && $stable(fall_ns_q[ch])));
   end
endmodule

bind evt_stamp_unit evt_stamp_chk #(.N_CH(N_CH), .SEC_W(SEC_W), .NS_W(NS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .irq       (irq),
   .rise_fire (rise_fire),
   .rise_en   (rise_en),
   .fall_en   (fall_en),
   .rise_lock (rise_lock),
   .fall_lock (fall_lock),
   .rise_pend (rise_pend),
   .fall_pend (fall_pend),
   .rise_ien  (rise_ien),
   .fall_ien  (fall_ien),
   .rise_sec_q(rise_sec_q),
   .fall_sec_q(fall_sec_q),
   .rise_ns_q (rise_ns_q),
   .fall_ns_q (fall_ns_q)
);

// File: tb/tb_evt_stamp_unit.sv
module tb_evt_stamp_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ev_in = '0;
   logic [31:0] time_sec = '0;
   logic [29:0] time_ns = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int unsigned tcount = 0;

   // bench model
   bit [7:0]  m_ren, m_fen, m_rlk, m_flk, m_rst, m_fst, m_enr, m_enf;
   bit [31:0] m_rsec [8];
   bit [31:0] m_fsec [8];
   bit [29:0] m_rns  [8];
   bit [29:0] m_fns  [8];

   evt_stamp_unit dut (
      .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .time_sec(time_sec), .time_ns(time_ns),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   always #5 clk = ~clk;

   function automatic logic [31:0] h_sec(int unsigned n);
      return (n * 32'h9E3779B1) ^ 32'h0000A5A5;
   endfunction
   function automatic logic [29:0] h_ns(int unsigned n);
      return 30'((n * 32'd7919 + 32'd13) % 32'd1000000000);
   endfunction

   // time counter takes a new value on every falling edge
   always @(negedge clk) begin
      tcount = tcount + 1;
      time_sec = h_sec(tcount);
      time_ns  = h_ns(tcount);
   end

   function automatic logic [31:0] exp_stat();
      return {m_fst, m_rst, 16'h0};
   endfunction
   function automatic logic [31:0] exp_ien();
      return {m_enf, m_enr, 16'h0};
   endfunction
   function automatic logic [31:0] exp_cfg();
      return {m_flk, m_rlk, m_fen, m_ren};
   endfunction
   function automatic logic exp_irq();
      return |((m_rst & m_enr) | (m_fst & m_enf));
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic set_cfg(logic [31:0] d);
      wr(4'd0, d);
      m_ren = d[7:0]; m_fen = d[15:8]; m_rlk = d[23:16]; m_flk = d[31:24];
   endtask
   task automatic w1c(logic [31:0] d);
      wr(4'd1, d);
      m_rst &= ~d[23:16]; m_fst &= ~d[31:24];
   endtask
   task automatic ien_set(logic [31:0] d);
      wr(4'd2, d);
      m_enr |= d[23:16]; m_enf |= d[31:24];
   endtask
   task automatic ien_clr(logic [31:0] d);
      wr(4'd3, d);
      m_enr &= ~d[23:16]; m_enf &= ~d[31:24];
   endtask

   // model of a capture at the third clock edge after the input change
   task automatic model_edge(int ch, bit rising, int unsigned k);
      if (rising && m_ren[ch]) begin
         if (!(m_rlk[ch] && m_rst[ch])) begin
            m_rsec[ch] = h_sec(k + 2); m_rns[ch] = h_ns(k + 2);
         end
         m_rst[ch] = 1'b1;
      end
      if (!rising && m_fen[ch]) begin
         if (!(m_flk[ch] && m_fst[ch])) begin
            m_fsec[ch] = h_sec(k + 2); m_fns[ch] = h_ns(k + 2);
         end
         m_fst[ch] = 1'b1;
      end
   endtask

   task automatic toggle(int ch);
      int unsigned k;
      bit nv;
      @(negedge clk);
      nv = ~ev_in[ch];
      ev_in[ch] = nv;
      #1 k = tcount;
      model_edge(ch, nv, k);
      repeat (3) @(negedge clk);
   endtask

   task automatic check_chan(string tag, int ch);
      logic [31:0] d;
      wr(4'd4, 32'(ch) << 8);
      rd(4'd5, d); chk({tag, " R10 rise sec"}, d, m_rsec[ch]);
      rd(4'd6, d); chk({tag, " R10 rise ns"},  d, {2'b0, m_rns[ch]});
      rd(4'd7, d); chk({tag, " R10 fall sec"}, d, m_fsec[ch]);
      rd(4'd8, d); chk({tag, " R10 fall ns"},  d, {2'b0, m_fns[ch]});
   endtask

   task automatic check_stat(string tag);
      logic [31:0] d;
      rd(4'd1, d);
      chk({tag, " status"}, d, exp_stat());
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #1_000_000;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] d, held;
      int unsigned k;
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'd0, d); chk("R1 config", d, 32'h0);
      check_stat("R1");
      rd(4'd2, d); chk("R1 enables", d, 32'h0);
      rd(4'd4, d); chk("R1 select", d, 32'h0);
      check_chan("R1 ch0", 0);
      chk("R1 irq", 32'(irq), 32'h0);

      // R2 rising capture on channel 2
      set_cfg(32'h0000_0004);
      rd(4'd0, d); chk("R2 config readback", d, exp_cfg());
      ien_set(32'h0004_0000);
      toggle(2);
      check_stat("R2");
      chk("R8 irq after capture", 32'(irq), 32'h1);
      check_chan("R2 ch2", 2);

      // R4 falling edge not enabled on channel 2
      toggle(2);
      check_stat("R4");
      check_chan("R4 ch2", 2);

      // R3 / R5 falling capture with lock on channel 5
      set_cfg(32'h2000_2004);
      toggle(5); toggle(5);
      check_stat("R3");
      check_chan("R3 ch5", 5);
      toggle(5); toggle(5);
      check_chan("R5 locked ch5", 5);
      w1c(32'h2000_0000);
      check_stat("R6 clear");
      toggle(5); toggle(5);
      check_chan("R5 relocked ch5", 5);

      // R6 writing zero changes nothing
      w1c(32'h0);
      check_stat("R6 zero write");

      // R7 / R8 enable set and clear
      ien_set(32'h2000_0000);
      rd(4'd2, d); chk("R7 enables at set address", d, exp_ien());
      ien_clr(32'h0004_0000);
      rd(4'd3, d); chk("R7 enables at clear address", d, exp_ien());
      chk("R8 irq fall5", 32'(irq), 32'(exp_irq()));
      ien_clr(32'h2000_0000);
      chk("R8 irq masked", 32'(irq), 32'h0);

      // R9 capture and clear on the same edge, channel 1
      set_cfg(32'h0000_0002);
      toggle(1); toggle(1);
      check_stat("R9 setup");
      @(negedge clk);
      ev_in[1] = 1'b1;
      #1 k = tcount;
      model_edge(1, 1'b1, k);
      @(negedge clk);
      wr(4'd1, 32'h0002_0000);
      repeat (2) @(negedge clk);
      check_stat("R9 capture wins");
      check_chan("R9 ch1", 1);

      // R11 read data holds while rd_en is low
      wr(4'd4, 32'h0000_0100);
      rd(4'd5, held);
      chk("R11 read value", held, m_rsec[1]);
      rd_addr = 4'd1;
      repeat (2) @(negedge clk);
      chk("R11 read hold", rd_data, held);

      // constrained random mix
      for (int it = 0; it < 60; it++) begin
         int unsigned act = $urandom % 8;
         case (act)
            0: set_cfg($urandom);
            1: ien_set($urandom & 32'hFFFF_0000);
            2: ien_clr($urandom & 32'hFFFF_0000);
            3: w1c($urandom & 32'hFFFF_0000);
            default: toggle(int'($urandom % 8));
         endcase
         chk("R8 random irq", 32'(irq), 32'(exp_irq()));
         if (it % 6 == 5) begin
            int ch = int'($urandom % 8);
            check_stat("R2/R3 random");
            check_chan("R5 random", ch);
         end
      end

      finish_run();
   end
endmodule